// File: doc/BRIEF.md
# DMA Burst Boundary Splitter

This block takes one DMA request and breaks it into a series of burst commands for a downstream bus master. A request carries a byte start address, a total length counted in 64-bit double words, a burst size code and a one-bit split-mode select. The block then issues commands one at a time over a valid/ready handshake. Each command holds an address, a length in double words and a hold-bus flag.

No command ever crosses a 256-byte line, which is 32 double words. The block supports two ways of handling a start address that is not aligned to the burst size. In mode 0, which is the default, it first issues a short burst up to the next multiple of the burst size and then issues full bursts. In mode 1, it issues full bursts from the start address. A burst that would cross a 256-byte line is cut at that line into two pieces, and the pieces go out back to back. The first piece raises the hold-bus flag.

The last burst of a transfer is shortened to the number of double words left, and it still obeys the line rule. A zero-length request finishes with a done pulse and no commands. A start address whose low three bits are not zero raises an error pulse, and no commands are issued.

Top module: `dma_burst_splitter`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_valid`, `busy`, `done` and `err` are all low.
- R2: For every issued command, the double-word index `cmd_addr[7:3]` plus `cmd_len` is at most 32. No burst crosses a 256-byte line.
- R3: In mode 0 (`req_mode`=0), with size S and start double-word index i, the first burst is S - (i mod S) long. Every later burst is S long. Each is limited to the double words still left.
- R4: In mode 1 (`req_mode`=1), each burst is S long, limited to the double words left. When such a burst would cross a 256-byte line, it is issued as two commands instead. The first runs up to the line and has `cmd_hold`=1. The second is the next command, starts at the line (`cmd_addr[7:0]`=0), carries the rest and has `cmd_hold`=0.
- R5: The first command address equals the request address. Each later address equals the previous address plus 8 times the previous length. The lengths add up to `req_len`.
- R6: `req_size` codes 0, 1, 2 and 3 select S = 1, 2, 4 and 8 double words. Every `cmd_len` is at least 1 and at most S.
- R7: A command moves on only on a cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and `cmd_ready` is low, `cmd_addr`, `cmd_len` and `cmd_hold` hold steady.
- R8: `done` is high for exactly the one cycle after the last command is accepted, and `cmd_valid` is low in that cycle.
- R9: A request with `req_len`=0 gives `done` high in the cycle after the request, and no command is issued.
- R10: A request with `req_addr[2:0]` not zero gives `err` high for the one cycle after the request. It issues no command and raises no `done`.
- R11: A `req_valid` pulse while `busy` is high has no effect on the command sequence in progress.
- R12: `cmd_valid` rises in the cycle right after a valid request is accepted in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in double words |
| req_size | input | 2 | Burst size code, S = 1 << code |
| req_mode | input | 1 | 0: align first, 1: split at line only |
| busy | output | 1 | A request is being worked on |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_addr | output | ADDR_W | Command start byte address |
| cmd_len | output | 4 | Command length in double words |
| cmd_hold | output | 1 | Keep bus ownership for the next command |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle misaligned-request pulse |

## Verification
A request driven before clock edge k leads to `cmd_valid` high after edge k. For zero-length and misaligned requests, `done` or `err` is high after edge k instead. An acceptance at edge e shows the next command after e, and after the last acceptance `done` is high after e. `busy` is low again one edge later. The bench drives and samples only on falling edges, so each of these results is read half a period after the edge that produces it. The sweep covers every start double-word index within a line, for both modes, all four sizes and several lengths, with random backpressure.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } bsplit_state_e;

endpackage

// File: rtl/bsplit_req_check.sv
module bsplit_req_check #(
    parameter int LEN_W      = 16,
    parameter int BYTE_SHIFT = 3
) (
    input  logic [BYTE_SHIFT-1:0] addr_low,
    input  logic [LEN_W-1:0]      len,
    output logic                  misaligned,
    output logic                  zero_len
);
    always_comb begin
        misaligned = (addr_low != '0);
        zero_len   = (len == '0);
    end
endmodule

// File: rtl/bsplit_len_calc.sv
module bsplit_len_calc #(
    parameter int LEN_W         = 16,
    parameter int BOUND_DW      = 32,
    parameter int MAX_SIZE_LOG2 = 3,
    localparam int BOUND_LOG2   = $clog2(BOUND_DW),
    localparam int CMD_LEN_W    = MAX_SIZE_LOG2 + 1,
    localparam int SIZE_W       = $clog2(MAX_SIZE_LOG2 + 1)
) (
    input  logic [BOUND_LOG2-1:0] dw_idx,
    input  logic [LEN_W-1:0]      rem,
    input  logic [SIZE_W-1:0]     size_code,
    input  logic                  mode,
    input  logic [CMD_LEN_W-1:0]  tail,
    output logic [CMD_LEN_W-1:0]  len,
    output logic                  hold,
    output logic [CMD_LEN_W-1:0]  tail_next
);
    logic [LEN_W-1:0] size_dw;
    logic [LEN_W-1:0] offset;
    logic [LEN_W-1:0] align_len;
    logic [LEN_W-1:0] room;
    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] capped;
    logic [LEN_W-1:0] len_w;

    always_comb begin
        size_dw   = LEN_W'(1) << size_code;
        offset    = LEN_W'(dw_idx) & (size_dw - LEN_W'(1));
        align_len = size_dw - offset;
        room      = LEN_W'(BOUND_DW) - LEN_W'(dw_idx);
        base      = mode ? size_dw : align_len;
        capped    = (rem < base) ? rem : base;
        hold      = 1'b0;
        tail_next = '0;
        if (tail != '0) begin
            // second piece of a split, issued right after the first
            len_w = LEN_W'(tail);
        end else if (mode && (capped > room)) begin
            len_w     = room;
            hold      = 1'b1;
            tail_next = CMD_LEN_W'(capped - room);
        end else begin
            len_w = capped;
        end
        len = CMD_LEN_W'(len_w);
    end
endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter #(
    parameter int ADDR_W        = 32,
    parameter int LEN_W         = 16,
    parameter int BOUND_DW      = 32,
    parameter int MAX_SIZE_LOG2 = 3,
    localparam int BYTE_SHIFT   = 3,
    localparam int BOUND_LOG2   = $clog2(BOUND_DW),
    localparam int CMD_LEN_W    = MAX_SIZE_LOG2 + 1,
    localparam int SIZE_W       = $clog2(MAX_SIZE_LOG2 + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic                 req_mode,
    output logic                 busy,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic [CMD_LEN_W-1:0] cmd_len,
    output logic                 cmd_hold,
    output logic                 done,
    output logic                 err
);
    import bsplit_pkg::*;

    typedef struct packed {
        bsplit_state_e          state;
        logic [ADDR_W-1:0]      addr;
        logic [LEN_W-1:0]       rem;
        logic [SIZE_W-1:0]      size;
        logic                   mode;
        logic [CMD_LEN_W-1:0]   tail;
    } split_regs_t;

    split_regs_t regs_d, regs_q;

    logic                 req_misaligned;
    logic                 req_zero;
    logic [CMD_LEN_W-1:0] burst_len;
    logic                 burst_hold;
    logic [CMD_LEN_W-1:0] burst_tail;

    bsplit_req_check #(
        .LEN_W     (LEN_W),
        .BYTE_SHIFT(BYTE_SHIFT)
    ) i_req_check (
        .addr_low  (req_addr[BYTE_SHIFT-1:0]),
        .len       (req_len),
        .misaligned(req_misaligned),
        .zero_len  (req_zero)
    );

    bsplit_len_calc #(
        .LEN_W        (LEN_W),
        .BOUND_DW     (BOUND_DW),
        .MAX_SIZE_LOG2(MAX_SIZE_LOG2)
    ) i_len_calc (
        .dw_idx   (regs_q.addr[BYTE_SHIFT +: BOUND_LOG2]),
        .rem      (regs_q.rem),
        .size_code(regs_q.size),
        .mode     (regs_q.mode),
        .tail     (regs_q.tail),
        .len      (burst_len),
        .hold     (burst_hold),
        .tail_next(burst_tail)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    regs_d.addr = req_addr;
                    regs_d.rem  = req_len;
                    regs_d.size = req_size;
                    regs_d.mode = req_mode;
                    regs_d.tail = '0;
                    if (req_misaligned) begin
                        regs_d.state = ST_ERR;
                    end else if (req_zero) begin
                        regs_d.state = ST_DONE;
                    end else begin
                        regs_d.state = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (cmd_ready) begin
                    regs_d.addr = regs_q.addr + (ADDR_W'(burst_len) << BYTE_SHIFT);
                    regs_d.rem  = regs_q.rem - LEN_W'(burst_len);
                    regs_d.tail = burst_tail;
                    if (regs_q.rem == LEN_W'(burst_len)) begin
                        regs_d.state = ST_DONE;
                    end
                end
            end
            ST_DONE, ST_ERR: begin
                regs_d.state = ST_IDLE;
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, addr: '0, rem: '0, size: '0, mode: 1'b0, tail: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        busy      = (regs_q.state != ST_IDLE);
        cmd_valid = (regs_q.state == ST_RUN);
        cmd_addr  = regs_q.addr;
        cmd_len   = burst_len;
        cmd_hold  = burst_hold && cmd_valid;
        done      = (regs_q.state == ST_DONE);
        err       = (regs_q.state == ST_ERR);
    end

    // ------------------------------------------------------------ checks
    assert_no_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (({1'b0, cmd_addr[BYTE_SHIFT +: BOUND_LOG2]}
                        + (BOUND_LOG2 + 1)'(cmd_len)) <= (BOUND_LOG2 + 1)'(BOUND_DW)));

    assert_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cmd_len != '0) && (cmd_len <= (CMD_LEN_W'(1) << regs_q.size))));

    assert_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_hold)));

    assert_hold_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_hold) |=>
            (cmd_valid && (cmd_addr[BYTE_SHIFT +: BOUND_LOG2] == '0) && !cmd_hold));

    assert_done_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (regs_q.rem == LEN_W'(cmd_len))) |=> (done && !cmd_valid));

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!cmd_valid && !done));

    assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && (req_len == '0) && (req_addr[BYTE_SHIFT-1:0] == '0))
            |=> (done && !cmd_valid));
endmodule

// File: tb/test_dma_burst_splitter.sv
module test_dma_burst_splitter;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [1:0]        req_size = '0;
    logic              req_mode = 1'b0;
    logic              busy;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [ADDR_W-1:0] cmd_addr;
    logic [3:0]        cmd_len;
    logic              cmd_hold;
    logic              done;
    logic              err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;   // 50 MHz

    dma_burst_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_dma_burst_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_size(req_size), .req_mode(req_mode), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_hold(cmd_hold), .done(done), .err(err));

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    task automatic send_req(input logic mode, input int szc, input logic [ADDR_W-1:0] a, input int len);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_len   = LEN_W'(len);
        req_size  = 2'(szc);
        req_mode  = mode;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_transfer(input logic mode, input int szc, input logic [ADDR_W-1:0] a,
                                input int len, input bit poke);
        int s = 1 << szc;
        longint eaddr = a;
        int erem = len;
        int etail = 0;
        int total = 0;
        int guard = 0;
        bit first = 1;
        send_req(mode, szc, a, len);
        chk(cmd_valid === 1'b1, "R12 cmd_valid after request", cmd_valid, 1);
        while (erem > 0 && guard < 2000) begin
            int dw = int'(eaddr / 8);
            int elen;
            int ehold = 0;
            int ntail = 0;
            bit acc;
            guard++;
            if (etail > 0) begin
                elen = etail;
            end else if (!mode) begin
                elen = ((dw / s) + 1) * s - dw;
                if (elen > erem) elen = erem;
            end else begin
                int full = (s < erem) ? s : erem;
                int room = 32 - (dw % 32);
                if (full > room) begin
                    elen = room; ehold = 1; ntail = full - room;
                end else begin
                    elen = full;
                end
            end
            chk(cmd_valid === 1'b1, "R7 valid held until accepted", cmd_valid, 1);
            chk(cmd_addr === ADDR_W'(eaddr), "R5 cmd_addr", cmd_addr, eaddr);
            chk(int'(cmd_len) == elen, mode ? "R4 R6 cmd_len mode1" : "R3 R6 cmd_len mode0",
                cmd_len, elen);
            chk(int'(cmd_hold) == ehold, "R4 cmd_hold", cmd_hold, ehold);
            chk((int'(cmd_addr[7:3]) + int'(cmd_len)) <= 32, "R2 line crossing",
                int'(cmd_addr[7:3]) + int'(cmd_len), 32);
            if (poke && first) begin
                req_valid = 1'b1;           // R11: ignored while busy
                req_addr  = 32'h0000_0104;
                req_len   = 16'd3;
                req_mode  = ~mode;
            end
            first = 0;
            acc = lfsr[0] | lfsr[3];
            cmd_ready = acc;
            @(negedge clk);
            req_valid = 1'b0;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (acc) begin
                eaddr = eaddr + 8 * elen;
                erem  = erem - elen;
                etail = ntail;
                total = total + elen;
            end
        end
        cmd_ready = 1'b0;
        chk(total == len, "R5 lengths sum", total, len);
        chk(done === 1'b1 && cmd_valid === 1'b0, poke ? "R8 R11 done after last" : "R8 done after last",
            {done, cmd_valid}, 2'b10);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R8 done single pulse", {done, busy}, 0);
    endtask

    initial begin
        int lens[4] = '{1, 5, 12, 37};
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({cmd_valid, busy, done, err} === 4'b0, "R1 in reset", {cmd_valid, busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({cmd_valid, busy, done, err} === 4'b0, "R1 after reset", {cmd_valid, busy, done, err}, 0);

        // Figure-style cases
        run_transfer(1'b0, 2, 32'h0000_3FA8, 20, 0);   // R3: 3 then 4s
        run_transfer(1'b1, 2, 32'h0000_3FE8, 12, 0);   // R4: 3+1 split at line

        // R9: zero length
        send_req(1'b0, 2, 32'h0000_0040, 0);
        chk(done === 1'b1 && cmd_valid === 1'b0, "R9 zero length done", {done, cmd_valid}, 2'b10);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0 && cmd_valid === 1'b0, "R9 no command",
            {done, busy, cmd_valid}, 0);

        // R10: misaligned low bits
        for (int lo = 1; lo < 8; lo++) begin
            send_req(lo[0], 3, 32'h0000_0100 + 32'(lo), 9);
            chk(err === 1'b1 && cmd_valid === 1'b0 && done === 1'b0, "R10 error pulse",
                {err, cmd_valid, done}, 3'b100);
            @(negedge clk);
            chk(err === 1'b0 && busy === 1'b0 && cmd_valid === 1'b0 && done === 1'b0,
                "R10 no command", {err, busy, cmd_valid, done}, 0);
        end

        // Sweep: both modes, all sizes, every start index in a line, several lengths
        for (int m = 0; m < 2; m++)
            for (int sc = 0; sc < 4; sc++)
                for (int dw = 0; dw < 32; dw++)
                    for (int li = 0; li < 4; li++)
                        run_transfer(m[0], sc, 32'h0000_3F00 + 32'(dw * 8), lens[li], li == 1);

        finish_run();
    end
endmodule